// File: doc/BRIEF.md
# Interrupt Acceptance and Exception Entry Sequencer

This block stands between the interrupt sources of a small processor and its memory bus. Each cycle it looks at one non-maskable request, a set of on-chip requests and a set of external request lines. The on-chip and external lines each carry a 4-bit priority. The block picks one winner and tests it against the mask field of the current status register. Once a request is accepted, the block spends a fixed number of decision cycles, which depends on the class of the source. It then waits for the processor to report that its current sequence has finished. After that it runs the exception entry on the bus.

The entry has four longword accesses, always in the same order. The status word is pushed first, then the return address. Next the handler address is read from the vector table. Last, the fetch of the first handler instruction is issued. Each access stays on the bus until the memory answers with ready, so the total response time depends on the decision length, the time spent waiting for the processor and the wait states of the three accesses that come before the fetch. Partway through the entry, the block publishes a new status word, with the mask raised to the accepted level, together with the lowered stack pointer. The processor loads both from these outputs.

Top module: `irq_entry_seq`

## Requirements
- R1: A maskable request (on-chip or external) is accepted only when its priority is strictly greater than the mask field `cpu_sr[7:4]`. The non-maskable request is always accepted, whatever the mask.
- R2: The non-maskable request wins over every other request. Among maskable requests the highest priority wins. On a tie, on-chip lines win over external lines, and a lower index wins within a class. The vector number is 11 for the non-maskable request, 64+i for on-chip line i and 80+i for external line i. `take_pulse` is high with `take_vec` for exactly the one cycle that follows the accepting edge.
- R3: The decision lasts 2 cycles for the non-maskable request and for on-chip sources, and 3 cycles for external sources. After that, each rising edge at which `cpu_seq_done` is low adds one wait cycle.
- R4: The entry makes its accesses in this order: a write of `cpu_sr` to SP-4, a write of `cpu_pc` to SP-8, a read from `vec_base` + 4*vector, and then a read (the fetch) from the address returned by that vector read. `bus_we` is 1 for the writes and 0 for the reads.
- R5: The fetch request first appears L cycles after the accepting edge, where L = D + X + 5 + m1 + m2 + m3. D is the decision length, X is the number of wait cycles, and m1, m2 and m3 are the cycles for which the SR save, the PC save and the vector read hold `bus_req`. With no waits L is 10 for non-maskable and on-chip sources and 11 for external sources.
- R6: An access holds `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` unchanged until a rising edge at which `bus_ready` is high.
- R7: `mask_upd` pulses for one cycle after both saves have completed and before the vector read begins. With it, `sr_new` equals `cpu_sr` with bits [7:4] replaced by the accepted priority (15 for the non-maskable request), and `sp_new` equals SP-8.
- R8: While an entry is in progress (`busy` high), no further request is accepted. A request that is still pending is accepted once the block has returned to idle.
- R9: After reset, `busy`, `bus_req`, `take_pulse` and `mask_upd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request |
| oc_req | input | N_OC | On-chip request lines |
| oc_prio | input | 4*N_OC | On-chip priorities, 4 bits per line, line i at [4i+3:4i] |
| ext_req | input | N_EXT | External request lines |
| ext_prio | input | 4*N_EXT | External priorities, 4 bits per line |
| cpu_seq_done | input | 1 | Processor has finished its current sequence |
| cpu_sr | input | DW | Current status register, mask in [7:4] |
| cpu_pc | input | DW | Return address to be saved |
| cpu_sp | input | DW | Current stack pointer |
| vec_base | input | DW | Base address of the vector table |
| bus_rdata | input | DW | Read data from memory |
| bus_ready | input | 1 | Memory completes the current access |
| take_pulse | output | 1 | One-cycle acceptance strobe |
| take_vec | output | 8 | Vector number of the accepted source |
| mask_upd | output | 1 | One-cycle strobe for loading sr_new and sp_new |
| sr_new | output | DW | Status word with the raised mask |
| sp_new | output | DW | Stack pointer after both pushes |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | DW | Access address |
| bus_wdata | output | DW | Write data |
| busy | output | 1 | An acceptance or entry is in progress |

## Verification
The acceptance strobe is due at the first falling edge after the edge that samples the request. The fetch address is due exactly D + X + 5 + m1 + m2 + m3 cycles after that edge, and the mask update is due in the single gap between the PC save and the vector read. The bench counts falling edges from the acceptance strobe. It raises `cpu_seq_done` and answers each access with a programmed number of wait states, so it knows in which cycle each of these results must appear. It compares every access against a queue of expected transfers on the first cycle the access is seen, and checks that the access stays on the bus until it is answered.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEC, ST_WAIT, ST_GAP1, ST_SRW, ST_GAP2,
    ST_PCW, ST_GAP3, ST_VRD, ST_GAP4, ST_GAP5, ST_FETCH
  } ent_state_e;

  typedef struct packed {
    logic              nmi;
    logic              ext;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } win_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_entry_pkg::*;
#(
  parameter int N_OC     = 4,
  parameter int N_EXT    = 4,
  parameter int NMI_VEC  = 11,
  parameter int OC_VEC0  = 64,
  parameter int EXT_VEC0 = 80
) (
  input  logic                    nmi_req,
  input  logic [N_OC-1:0]         oc_req,
  input  logic [PRIO_W*N_OC-1:0]  oc_prio,
  input  logic [N_EXT-1:0]        ext_req,
  input  logic [PRIO_W*N_EXT-1:0] ext_prio,
  input  logic [PRIO_W-1:0]       mask,
  output logic                    hit,
  output win_t                    win
);
  logic [PRIO_W-1:0] oc_p  [N_OC];
  logic [PRIO_W-1:0] ext_p [N_EXT];

  for (genvar g = 0; g < N_OC; g++) begin : g_oc
    assign oc_p[g] = oc_prio[g*PRIO_W +: PRIO_W];
  end
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign ext_p[g] = ext_prio[g*PRIO_W +: PRIO_W];
  end

  // Scan order gives tie preference: on-chip before external, low index first.
  always_comb begin
    hit = 1'b0;
    win = '0;
    if (nmi_req) begin
      hit      = 1'b1;
      win.nmi  = 1'b1;
      win.prio = '1;
      win.vec  = VEC_W'(NMI_VEC);
    end else begin
      for (int i = 0; i < N_OC; i++) begin
        if (oc_req[i] && (oc_p[i] > mask) && (!hit || oc_p[i] > win.prio)) begin
          hit      = 1'b1;
          win.ext  = 1'b0;
          win.prio = oc_p[i];
          win.vec  = VEC_W'(OC_VEC0 + i);
        end
      end
      for (int i = 0; i < N_EXT; i++) begin
        if (ext_req[i] && (ext_p[i] > mask) && (!hit || ext_p[i] > win.prio)) begin
          hit      = 1'b1;
          win.ext  = 1'b1;
          win.prio = ext_p[i];
          win.vec  = VEC_W'(EXT_VEC0 + i);
        end
      end
    end
  end
endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int DW       = 32,
  parameter int MASK_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  win_t              win,
  input  logic              seq_done,
  input  logic [DW-1:0]     sr_in,
  input  logic [DW-1:0]     pc_in,
  input  logic [DW-1:0]     sp_in,
  input  logic [DW-1:0]     vbase_in,
  input  logic [DW-1:0]     rdata,
  input  logic              ready,
  output logic              take_pulse,
  output logic [VEC_W-1:0]  take_vec,
  output logic              mask_upd,
  output logic [DW-1:0]     sr_new,
  output logic [DW-1:0]     sp_new,
  output logic              bus_req,
  output logic              bus_we,
  output logic [DW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic              busy
);
  localparam logic [DW-1:0] LW = DW'(4);

  ent_state_e st_q, st_d;
  logic [1:0] cnt_q, cnt_d;
  win_t       cur_q;
  logic [DW-1:0] sr_q, pc_q, sp_q, vb_q, hnd_q;
  logic       cap_src, cap_ctx, cap_hnd, dec_last;

  assign dec_last = (cnt_q == (cur_q.ext ? 2'd2 : 2'd1));
  assign cap_src  = (st_q == ST_IDLE) && hit;
  assign cap_ctx  = ((st_q == ST_DEC && dec_last) || st_q == ST_WAIT) && seq_done;
  assign cap_hnd  = (st_q == ST_VRD) && ready;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE:  if (hit) begin st_d = ST_DEC; cnt_d = 2'd0; end
      ST_DEC: begin
        if (dec_last) st_d = seq_done ? ST_GAP1 : ST_WAIT;
        else          cnt_d = cnt_q + 2'd1;
      end
      ST_WAIT:  if (seq_done) st_d = ST_GAP1;
      ST_GAP1:  st_d = ST_SRW;
      ST_SRW:   if (ready) st_d = ST_GAP2;
      ST_GAP2:  st_d = ST_PCW;
      ST_PCW:   if (ready) st_d = ST_GAP3;
      ST_GAP3:  st_d = ST_VRD;
      ST_VRD:   if (ready) st_d = ST_GAP4;
      ST_GAP4:  st_d = ST_GAP5;
      ST_GAP5:  st_d = ST_FETCH;
      ST_FETCH: if (ready) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= 2'd0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      sr_q  <= '0;
      pc_q  <= '0;
      sp_q  <= '0;
      vb_q  <= '0;
      hnd_q <= '0;
    end else begin
      if (cap_src) cur_q <= win;
      if (cap_ctx) begin
        sr_q <= sr_in;
        pc_q <= pc_in;
        sp_q <= sp_in;
        vb_q <= vbase_in;
      end
      if (cap_hnd) hnd_q <= rdata;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign take_pulse = (st_q == ST_DEC) && (cnt_q == 2'd0);
  assign take_vec   = cur_q.vec;
  assign mask_upd   = (st_q == ST_GAP3);
  assign sp_new     = sp_q - LW - LW;

  always_comb begin
    sr_new = sr_q;
    sr_new[MASK_LSB +: PRIO_W] = cur_q.nmi ? {PRIO_W{1'b1}} : cur_q.prio;
  end

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (st_q)
      ST_SRW: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = sp_q - LW; bus_wdata = sr_q;
      end
      ST_PCW: begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = sp_q - LW - LW; bus_wdata = pc_q;
      end
      ST_VRD: begin
        bus_req = 1'b1; bus_addr = vb_q + DW'({cur_q.vec, 2'b00});
      end
      ST_FETCH: begin
        bus_req = 1'b1; bus_addr = hnd_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int N_OC     = 4,
  parameter int N_EXT    = 4,
  parameter int DW       = 32,
  parameter int NMI_VEC  = 11,
  parameter int OC_VEC0  = 64,
  parameter int EXT_VEC0 = 80,
  parameter int MASK_LSB = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    nmi_req,
  input  logic [N_OC-1:0]         oc_req,
  input  logic [4*N_OC-1:0]       oc_prio,
  input  logic [N_EXT-1:0]        ext_req,
  input  logic [4*N_EXT-1:0]      ext_prio,
  input  logic                    cpu_seq_done,
  input  logic [DW-1:0]           cpu_sr,
  input  logic [DW-1:0]           cpu_pc,
  input  logic [DW-1:0]           cpu_sp,
  input  logic [DW-1:0]           vec_base,
  input  logic [DW-1:0]           bus_rdata,
  input  logic                    bus_ready,
  output logic                    take_pulse,
  output logic [7:0]              take_vec,
  output logic                    mask_upd,
  output logic [DW-1:0]           sr_new,
  output logic [DW-1:0]           sp_new,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic [DW-1:0]           bus_addr,
  output logic [DW-1:0]           bus_wdata,
  output logic                    busy
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       hit;
  win_t       win;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irq_pick #(
    .N_OC(N_OC), .N_EXT(N_EXT), .NMI_VEC(NMI_VEC),
    .OC_VEC0(OC_VEC0), .EXT_VEC0(EXT_VEC0)
  ) u_pick (
    .nmi_req (nmi_req),
    .oc_req  (oc_req),
    .oc_prio (oc_prio),
    .ext_req (ext_req),
    .ext_prio(ext_prio),
    .mask    (cpu_sr[MASK_LSB +: PRIO_W]),
    .hit     (hit),
    .win     (win)
  );

  entry_fsm #(.DW(DW), .MASK_LSB(MASK_LSB)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hit       (hit),
    .win       (win),
    .seq_done  (cpu_seq_done),
    .sr_in     (cpu_sr),
    .pc_in     (cpu_pc),
    .sp_in     (cpu_sp),
    .vbase_in  (vec_base),
    .rdata     (bus_rdata),
    .ready     (bus_ready),
    .take_pulse(take_pulse),
    .take_vec  (take_vec),
    .mask_upd  (mask_upd),
    .sr_new    (sr_new),
    .sp_new    (sp_new),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take_pulse,
  input logic          mask_upd,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_ready,
  input logic [DW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          busy
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  assert_take_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> $past(!busy));

  assert_take_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |=> !take_pulse);

  assert_vector_after_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_upd |=> (bus_req && !bus_we));

  assert_update_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_upd |-> (!bus_req && busy));

  assert_write_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_addr[1:0] == 2'b00));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !take_pulse && !mask_upd));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
  localparam int NOC = 4;
  localparam int NEX = 4;

  logic clk;
  logic rst_n;
  logic nmi_req;
  logic [NOC-1:0]   oc_req;
  logic [4*NOC-1:0] oc_prio;
  logic [NEX-1:0]   ext_req;
  logic [4*NEX-1:0] ext_prio;
  logic cpu_seq_done;
  logic [31:0] cpu_sr, cpu_pc, cpu_sp, vec_base, bus_rdata;
  logic bus_ready;
  logic take_pulse, mask_upd, bus_req, bus_we, busy;
  logic [7:0] take_vec;
  logic [31:0] sr_new, sp_new, bus_addr, bus_wdata;

  int total = 0;
  int bad   = 0;

  irq_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .oc_req(oc_req), .oc_prio(oc_prio),
    .ext_req(ext_req), .ext_prio(ext_prio), .cpu_seq_done(cpu_seq_done),
    .cpu_sr(cpu_sr), .cpu_pc(cpu_pc), .cpu_sp(cpu_sp), .vec_base(vec_base),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .take_pulse(take_pulse),
    .take_vec(take_vec), .mask_upd(mask_upd), .sr_new(sr_new), .sp_new(sp_new),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_reqs();
    nmi_req = 1'b0;
    oc_req  = '0;
    ext_req = '0;
  endtask

  task automatic set_mask(input int m);
    cpu_sr[7:4] = 4'(m);
  endtask

  // Behavioural model of one acceptance and entry, compared every cycle.
  task automatic run_entry(input int vec, input bit ext, input bit nmi, input int prio,
                           input int x, input int w0, input int w1, input int w2,
                           input int w3, input bit immediate, input int inject_at);
    int d, lat, n, idx, done, wl, guard, extra_take, mu_seen;
    bit inacc, taken;
    int waits[4];
    logic [31:0] ea[4];
    logic [31:0] ed[4];
    bit ew[4];
    logic [31:0] es;
    d   = ext ? 3 : 2;
    lat = d + x + 5 + (w0 + 1) + (w1 + 1) + (w2 + 1);
    waits[0] = w0; waits[1] = w1; waits[2] = w2; waits[3] = w3;
    bus_rdata = 32'h0000_8000 + 32'(vec * 32);
    ea[0] = cpu_sp - 4; ed[0] = cpu_sr; ew[0] = 1'b1;
    ea[1] = cpu_sp - 8; ed[1] = cpu_pc; ew[1] = 1'b1;
    ea[2] = vec_base + 32'(vec * 4); ed[2] = '0; ew[2] = 1'b0;
    ea[3] = bus_rdata; ed[3] = '0; ew[3] = 1'b0;
    es = cpu_sr;
    es[7:4] = nmi ? 4'hF : 4'(prio);
    n = 0; idx = 0; done = 0; wl = 0; guard = 0; extra_take = 0; mu_seen = 0;
    inacc = 1'b0; taken = 1'b0;
    while (done < 4 && guard < 500) begin
      @(negedge clk);
      guard++;
      if (!taken) begin
        if (take_pulse) begin
          taken = 1'b1;
          n = 1;
          chk(take_vec == 8'(vec), "R2", "accepted vector", take_vec, vec);
          if (immediate) chk(guard == 1, "R1", "acceptance cycle", guard, 1);
          clear_reqs();
          cpu_seq_done = 1'b0;
        end
      end else begin
        n++;
        if (take_pulse) extra_take++;
      end
      if (taken) begin
        if (n == d + x) cpu_seq_done = 1'b1;
        if (n == inject_at) nmi_req = 1'b1;
        if (bus_ready) begin
          inacc = 1'b0;
          bus_ready = 1'b0;
          done++;
        end
        if (mask_upd) begin
          mu_seen++;
          chk(done == 2, "R7", "saves done at update", done, 2);
          chk(sr_new == es, "R7", "raised status word", sr_new, es);
          chk(sp_new == cpu_sp - 8, "R7", "new stack pointer", sp_new, cpu_sp - 8);
        end
        if (bus_req && !inacc && done < 4) begin
          chk(bus_addr == ea[idx], "R4", "access address", bus_addr, ea[idx]);
          chk(bus_we == ew[idx], "R4", "access direction", bus_we, ew[idx]);
          if (ew[idx]) chk(bus_wdata == ed[idx], "R4", "write data", bus_wdata, ed[idx]);
          if (idx == 3) chk(n == lat + 1, "R5", "fetch start cycle", n - 1, lat);
          if (idx == 0) chk(n == d + x + 2, "R3", "entry start cycle", n - 1, d + x + 1);
          inacc = 1'b1;
          wl = waits[idx];
          idx++;
        end else if (inacc && !bus_req) begin
          chk(1'b0, "R6", "request dropped before ready", 0, 1);
        end
        if (inacc) begin
          if (wl == 0) bus_ready = 1'b1;
          else wl--;
        end
        if (done == 4) chk(!busy, "R8", "idle after fetch", busy, 0);
      end
    end
    chk(done == 4, "R4", "completed accesses", done, 4);
    chk(mu_seen == 1, "R7", "update pulses", mu_seen, 1);
    chk(extra_take == 0, "R8", "acceptances during entry", extra_take, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clear_reqs();
    oc_prio = '0;
    ext_prio = '0;
    cpu_seq_done = 1'b1;
    cpu_sr = 32'hA5A5_0F03;
    cpu_pc = 32'h0000_1234;
    cpu_sp = 32'h0000_F000;
    vec_base = 32'h0000_0400;
    bus_rdata = '0;
    bus_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state
    chk(!busy && !bus_req && !take_pulse && !mask_upd, "R9", "outputs after reset",
        {busy, bus_req, take_pulse, mask_upd}, 0);

    // R1/R5: non-maskable with mask at 15, no waits: 10 cycles
    set_mask(15);
    nmi_req = 1'b1;
    run_entry(11, 1'b0, 1'b1, 15, 0, 0, 0, 0, 0, 1'b1, 0);

    // R3/R5: on-chip line 2, priority 5 over mask 3
    @(negedge clk);
    set_mask(3);
    oc_req[2] = 1'b1; oc_prio[8 +: 4] = 4'd5;
    run_entry(66, 1'b0, 1'b0, 5, 0, 0, 0, 0, 0, 1'b1, 0);

    // R3/R5: external line 1, priority 7: 11 cycles
    @(negedge clk);
    ext_req[1] = 1'b1; ext_prio[4 +: 4] = 4'd7;
    run_entry(81, 1'b1, 1'b0, 7, 0, 0, 0, 0, 0, 1'b1, 0);

    // R3/R5/R6: external line 3 with waits 1,2,0,3 and two processor wait cycles
    @(negedge clk);
    cpu_sp = 32'h0000_E010; cpu_pc = 32'h0000_5678;
    ext_req[3] = 1'b1; ext_prio[12 +: 4] = 4'd9;
    run_entry(83, 1'b1, 1'b0, 9, 2, 1, 2, 0, 3, 1'b1, 0);

    // R3: on-chip with three processor wait cycles and a slow fetch
    @(negedge clk);
    oc_req[0] = 1'b1; oc_prio[0 +: 4] = 4'd12;
    run_entry(64, 1'b0, 1'b0, 12, 3, 0, 1, 1, 2, 1'b1, 0);

    // R1: priority equal to mask is ignored
    @(negedge clk);
    set_mask(4);
    ext_req[1] = 1'b1; ext_prio[4 +: 4] = 4'd4;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (take_pulse || busy || bus_req) seen++;
      end
      chk(seen == 0, "R1", "activity for priority equal to mask", seen, 0);
    end
    set_mask(3);
    run_entry(81, 1'b1, 1'b0, 4, 0, 0, 0, 0, 0, 1'b1, 0);

    // R2: tie between on-chip 1 and external 0 at priority 9
    @(negedge clk);
    oc_req[1] = 1'b1; oc_prio[4 +: 4] = 4'd9;
    ext_req[0] = 1'b1; ext_prio[0 +: 4] = 4'd9;
    run_entry(65, 1'b0, 1'b0, 9, 0, 0, 0, 0, 0, 1'b1, 0);

    // R2: tie inside the on-chip class, lower index wins
    @(negedge clk);
    oc_req[0] = 1'b1; oc_prio[0 +: 4] = 4'd6;
    oc_req[2] = 1'b1; oc_prio[8 +: 4] = 4'd6;
    run_entry(64, 1'b0, 1'b0, 6, 0, 0, 0, 0, 0, 1'b1, 0);

    // R2: higher external priority beats on-chip
    @(negedge clk);
    oc_req[3] = 1'b1; oc_prio[12 +: 4] = 4'd11;
    ext_req[2] = 1'b1; ext_prio[8 +: 4] = 4'd12;
    run_entry(82, 1'b1, 1'b0, 12, 0, 0, 0, 0, 0, 1'b1, 0);

    // R2: non-maskable beats a priority 15 line
    @(negedge clk);
    oc_req[1] = 1'b1; oc_prio[4 +: 4] = 4'd15;
    nmi_req = 1'b1;
    run_entry(11, 1'b0, 1'b1, 15, 0, 0, 0, 0, 0, 1'b1, 0);

    // R8: non-maskable raised mid-entry waits for the entry to finish
    @(negedge clk);
    ext_req[0] = 1'b1; ext_prio[0 +: 4] = 4'd8;
    run_entry(80, 1'b1, 1'b0, 8, 1, 1, 1, 1, 1, 1'b1, 6);
    run_entry(11, 1'b0, 1'b1, 15, 0, 0, 0, 0, 0, 1'b0, 0);

    repeat (3) @(negedge clk);
    chk(!busy && !bus_req, "R8", "idle at end", busy, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule